// File: doc/BRIEF.md
# HDLC Receive Event Register

This block collects receive-side line and frame events of an HDLC channel into a 16-bit event register. It sits beside the receive deframer and listens to the decoded serial bit stream and to a few strobes from the deframer: one when a flag pattern has been recognised, one when a frame has closed, and one when a receive buffer has filled. A fourth strobe reports a glitch on the receive clock. From these it derives an idle event after a long run of ones, and a flag event at both the opening and the closing of each flag sequence. It also records the frame-close, buffer-full and clock-glitch strobes as events.

Software reads the event register and a mask register through a small register port. It clears events by writing ones to them. A single level interrupt request is raised one cycle after any set event bit is also enabled in the mask. The request stays up until software has cleared every such bit. Because the flag event is posted directly from the flag detector, the closing flag of a frame can appear in the register before the frame-close event, which comes from a slower path.

Top module: `hdlc_rx_evt`

## Requirements
- R1: A synchronous reset clears the event register, the mask register and the interrupt request to zero.
- R2: A write to address 0 clears every event bit whose data bit is 1. Bits written with 0 keep their value, and several bits may be cleared in one write. A write never sets an event bit.
- R3: Bits 15, 14, 13, 6 and 5 of both registers always read as 0, and writes to them have no effect. All other bits of the mask register (address 1) store the written value.
- R4: Event bits are set on the clock edge that samples the source strobe: bit 12 from the receive clock glitch strobe, bit 3 from the frame-close strobe and bit 0 from the buffer-full strobe.
- R5: Bit 8 (idle) is set on the edge that samples the fifteenth consecutive valid 1 bit. A valid 0 bit restarts the count. A run of ones sets the bit only once, however long the run is.
- R6: Bit 9 (flag) is set when a flag strobe arrives while no flag sequence is open. Further flag strobes inside an open sequence set nothing.
- R7: Bit 9 is also set, and the sequence is closed, on the edge that samples the eighth valid bit since the last flag strobe.
- R8: When a hardware source sets a bit in the same cycle that software clears it, the bit ends up set.
- R9: The interrupt request is 1 in the cycle after any bit is set in both the event register and the mask register. It is 0 in the cycle after no such bit remains.
- R10: The read data shows the event register when the address is 0 and the mask register when the address is 1, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Decoded receive data bit |
| rx_bit_vld | input | 1 | rx_bit carries a new bit this cycle |
| flag_hit | input | 1 | A flag pattern was recognised |
| frame_done | input | 1 | A receive frame has closed |
| buf_full | input | 1 | A receive buffer has been filled |
| rx_clk_glitch | input | 1 | A glitch was seen on the receive clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 event, 1 mask |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| evt_value | output | 16 | Current event register |
| irq_req | output | 1 | Level interrupt request |

## Verification
A one-bit slip in the ones counter or in the flag gap counter shows up at the ports on the very edge where bit 8 or bit 9 is expected to rise. It appears as a bit that comes one valid bit early or late, or as a second idle event inside one long run. A stuck flag-sequence state shows either as no closing event or as a fresh opening event on a strobe inside an open sequence. Errors in the clear or mask logic show in the register image and in the interrupt level one cycle later.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;

    localparam int EVT_W = 16;

    // event bit positions
    localparam int B_RBUF   = 0;
    localparam int B_FRAME  = 3;
    localparam int B_IDLE   = 8;
    localparam int B_FLAG   = 9;
    localparam int B_GLITCH = 12;

    // bits that hold state (reserved: 15..13, 6, 5)
    localparam logic [EVT_W-1:0] IMPL_MASK = 16'h1F9F;

    localparam logic ADDR_EVT  = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    typedef struct packed {
        logic glitch;
        logic flag;
        logic idle;
        logic frame;
        logic rbuf;
    } hw_evt_t;

    function automatic logic [EVT_W-1:0] evt_set_vec(hw_evt_t e);
        logic [EVT_W-1:0] v;
        v           = '0;
        v[B_GLITCH] = e.glitch;
        v[B_FLAG]   = e.flag;
        v[B_IDLE]   = e.idle;
        v[B_FRAME]  = e.frame;
        v[B_RBUF]   = e.rbuf;
        return v & IMPL_MASK;
    endfunction

endpackage

// File: rtl/hdlc_idle_det.sv
module hdlc_idle_det #(
    parameter int RUN = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_val,
    output logic idle_pulse
);
    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN - 1);
    localparam logic [CW-1:0] SAT  = CW'(RUN);

    logic [CW-1:0] ones_cnt;

    // fires once when the run reaches RUN; saturation keeps it quiet after
    assign idle_pulse = bit_vld && bit_val && (ones_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt <= '0;
        end else if (bit_vld) begin
            if (!bit_val) begin
                ones_cnt <= '0;
            end else if (ones_cnt != SAT) begin
                ones_cnt <= ones_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hdlc_flag_track.sv
module hdlc_flag_track #(
    parameter int GAP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic flag_hit,
    output logic flag_pulse
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);

    logic          in_seq;
    logic [CW-1:0] gap_cnt;
    logic          open_ev;
    logic          close_ev;

    assign open_ev    = flag_hit && !in_seq;
    assign close_ev   = in_seq && !flag_hit && bit_vld && (gap_cnt == LAST);
    assign flag_pulse = open_ev || close_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_seq  <= 1'b0;
            gap_cnt <= '0;
        end else if (flag_hit) begin
            in_seq  <= 1'b1;
            gap_cnt <= '0;
        end else if (close_ev) begin
            in_seq  <= 1'b0;
            gap_cnt <= '0;
        end else if (in_seq && bit_vld) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_evt_bank.sv
module hdlc_evt_bank
    import hdlc_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] set_vec,
    input  logic             wr,
    input  logic             addr,
    input  logic [EVT_W-1:0] wdata,
    output logic [EVT_W-1:0] evt_q,
    output logic [EVT_W-1:0] mask_q
);
    logic [EVT_W-1:0] clr_vec;
    logic [EVT_W-1:0] evt_n;

    always_comb begin
        clr_vec = (wr && addr == ADDR_EVT) ? wdata : '0;
        // hardware set is applied after the clear so it wins
        evt_n   = ((evt_q & ~clr_vec) | set_vec) & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= '0;
            mask_q <= '0;
        end else begin
            evt_q <= evt_n;
            if (wr && addr == ADDR_MASK) begin
                mask_q <= wdata & IMPL_MASK;
            end
        end
    end
endmodule

// File: rtl/hdlc_irq_gen.sv
module hdlc_irq_gen
    import hdlc_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] mask,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |(evt & mask & IMPL_MASK);
        end
    end
endmodule

// File: rtl/hdlc_rx_evt.sv
module hdlc_rx_evt
    import hdlc_evt_pkg::*;
#(
    parameter int IDLE_RUN = 15,
    parameter int FLAG_GAP = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_bit,
    input  logic        rx_bit_vld,
    input  logic        flag_hit,
    input  logic        frame_done,
    input  logic        buf_full,
    input  logic        rx_clk_glitch,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [15:0] evt_value,
    output logic        irq_req
);
    hw_evt_t          hw;
    logic             idle_p;
    logic             flag_p;
    logic [EVT_W-1:0] set_vec;
    logic [EVT_W-1:0] evt_r;
    logic [EVT_W-1:0] mask_r;

    hdlc_idle_det #(.RUN(IDLE_RUN)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (rx_bit_vld),
        .bit_val   (rx_bit),
        .idle_pulse(idle_p)
    );

    hdlc_flag_track #(.GAP(FLAG_GAP)) u_flag (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (rx_bit_vld),
        .flag_hit  (flag_hit),
        .flag_pulse(flag_p)
    );

    always_comb begin
        hw.glitch = rx_clk_glitch;
        hw.flag   = flag_p;
        hw.idle   = idle_p;
        hw.frame  = frame_done;
        hw.rbuf   = buf_full;
        set_vec   = evt_set_vec(hw);
    end

    hdlc_evt_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_vec(set_vec),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .evt_q  (evt_r),
        .mask_q (mask_r)
    );

    hdlc_irq_gen u_irq (
        .clk (clk),
        .rst (rst),
        .evt (evt_r),
        .mask(mask_r),
        .irq (irq_req)
    );

    assign evt_value = evt_r;
    assign reg_rdata = (reg_addr == ADDR_MASK) ? mask_r : evt_r;
endmodule

// File: rtl/hdlc_rx_evt_chk.sv
module hdlc_rx_evt_chk
    import hdlc_evt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rx_bit_vld,
    input logic        flag_hit,
    input logic        frame_done,
    input logic        buf_full,
    input logic        rx_clk_glitch,
    input logic [15:0] evt_value,
    input logic [15:0] mask,
    input logic        irq_req
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (evt_value == 16'h0 && mask == 16'h0 && !irq_req)); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((evt_value & ~IMPL_MASK) == 16'h0 && (mask & ~IMPL_MASK) == 16'h0)); // R3

    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (rst)
        (!rx_bit_vld && !flag_hit && !frame_done && !buf_full && !rx_clk_glitch)
        |=> ((evt_value & ~$past(evt_value)) == 16'h0)); // R2

    AST_FRAME_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> evt_value[B_FRAME]); // R8

    AST_BUF_SET: assert property (@(posedge clk) disable iff (rst)
        buf_full |=> evt_value[B_RBUF]); // R4

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        ((evt_value & mask) != 16'h0) |=> irq_req); // R9

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        ((evt_value & mask) == 16'h0) |=> !irq_req); // R9
endmodule

bind hdlc_rx_evt hdlc_rx_evt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_bit_vld   (rx_bit_vld),
    .flag_hit     (flag_hit),
    .frame_done   (frame_done),
    .buf_full     (buf_full),
    .rx_clk_glitch(rx_clk_glitch),
    .evt_value    (evt_value),
    .mask         (mask_r),
    .irq_req      (irq_req)
);

// File: tb/hdlc_rx_evt_bench.sv
module hdlc_rx_evt_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_bit = 1'b0;
    logic        rx_bit_vld = 1'b0;
    logic        flag_hit = 1'b0;
    logic        frame_done = 1'b0;
    logic        buf_full = 1'b0;
    logic        rx_clk_glitch = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_value;
    logic        irq_req;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_evt u_hdlc_rx_evt (
        .clk          (clk),
        .rst          (rst),
        .rx_bit       (rx_bit),
        .rx_bit_vld   (rx_bit_vld),
        .flag_hit     (flag_hit),
        .frame_done   (frame_done),
        .buf_full     (buf_full),
        .rx_clk_glitch(rx_clk_glitch),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .evt_value    (evt_value),
        .irq_req      (irq_req)
    );

    // {wr, addr, wdata, glitch, frame, buf, exp_evt, exp_irq}
    localparam logic [37:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 16'hFFFF, 3'b000, 16'h0000, 1'b0},
        {1'b0, 1'b0, 16'h0000, 3'b001, 16'h0001, 1'b0},
        {1'b0, 1'b0, 16'h0000, 3'b010, 16'h0009, 1'b1},
        {1'b0, 1'b0, 16'h0000, 3'b100, 16'h1009, 1'b1},
        {1'b1, 1'b0, 16'h0008, 3'b000, 16'h1001, 1'b1},
        {1'b1, 1'b0, 16'hE060, 3'b000, 16'h1001, 1'b1},
        {1'b1, 1'b0, 16'h1001, 3'b000, 16'h0000, 1'b1},
        {1'b0, 1'b0, 16'h0000, 3'b000, 16'h0000, 1'b0},
        {1'b1, 1'b1, 16'h0008, 3'b000, 16'h0000, 1'b0},
        {1'b0, 1'b0, 16'h0000, 3'b001, 16'h0001, 1'b0},
        {1'b0, 1'b0, 16'h0000, 3'b000, 16'h0001, 1'b0},
        {1'b1, 1'b0, 16'h0008, 3'b010, 16'h0009, 1'b0},
        {1'b0, 1'b0, 16'h0000, 3'b000, 16'h0009, 1'b1},
        {1'b1, 1'b0, 16'h0001, 3'b000, 16'h0008, 1'b1},
        {1'b1, 1'b0, 16'h0008, 3'b000, 16'h0000, 1'b1},
        {1'b0, 1'b0, 16'h0000, 3'b000, 16'h0000, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_bit     = b;
        rx_bit_vld = 1'b1;
        @(negedge clk);
        rx_bit_vld = 1'b0;
    endtask

    task automatic send_run(input logic b, input int n);
        for (int k = 0; k < n; k++) send_bit(b);
    endtask

    task automatic wr_reg(input logic a, input logic [15:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 1'b0;
    endtask

    task automatic pulse_flag();
        flag_hit = 1'b1;
        @(negedge clk);
        flag_hit = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 evt", evt_value, 16'h0000);
        check("R1 irq", {15'h0, irq_req}, 16'h0);
        reg_addr = 1'b1;
        #1;
        check("R1 mask", reg_rdata, 16'h0000);
        reg_addr = 1'b0;

        // table: R2 R3 R4 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [37:0] v;
            v             = VEC[i];
            reg_wr        = v[37];
            reg_addr      = v[36];
            reg_wdata     = v[35:20];
            rx_clk_glitch = v[19];
            frame_done    = v[18];
            buf_full      = v[17];
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 1'b0;
            rx_clk_glitch = 1'b0; frame_done = 1'b0; buf_full = 1'b0;
            check($sformatf("R2/R4/R8 evt step %0d", i), evt_value, v[16:1]);
            check($sformatf("R9 irq step %0d", i), {15'h0, irq_req}, {15'h0, v[0]});
        end

        // R10 read mux
        reg_addr = 1'b1; #1;
        check("R10 mask read", reg_rdata, 16'h0008);
        reg_addr = 1'b0; #1;
        check("R10 evt read", reg_rdata, evt_value);

        // R3 reserved mask bits
        wr_reg(1'b1, 16'hFFFF);
        reg_addr = 1'b1; #1;
        check("R3 mask rsvd", reg_rdata, 16'h1F9F);
        reg_addr = 1'b0;
        wr_reg(1'b1, 16'h0000);

        // R5 idle
        send_run(1'b1, 14);
        check("R5 14 ones", evt_value & 16'h0100, 16'h0000);
        send_bit(1'b1);
        check("R5 15th one", evt_value & 16'h0100, 16'h0100);
        wr_reg(1'b0, 16'h0100);
        send_run(1'b1, 20);
        check("R5 once per run", evt_value & 16'h0100, 16'h0000);
        send_bit(1'b0);
        send_run(1'b1, 14);
        send_bit(1'b0);
        send_run(1'b1, 14);
        check("R5 zero restarts", evt_value & 16'h0100, 16'h0000);
        send_bit(1'b1);
        check("R5 new run", evt_value & 16'h0100, 16'h0100);
        wr_reg(1'b0, 16'hFFFF);

        // R6 R7 flag sequence
        pulse_flag();
        check("R6 flag open", evt_value & 16'h0200, 16'h0200);
        wr_reg(1'b0, 16'h0200);
        send_run(1'b0, 7);
        check("R7 7 bits", evt_value & 16'h0200, 16'h0000);
        pulse_flag();
        check("R6 no reopen", evt_value & 16'h0200, 16'h0000);
        send_run(1'b0, 7);
        check("R7 still open", evt_value & 16'h0200, 16'h0000);
        send_bit(1'b0);
        check("R7 flag close", evt_value & 16'h0200, 16'h0200);
        wr_reg(1'b0, 16'h0200);
        send_run(1'b0, 10);
        check("R7 closed quiet", evt_value & 16'h0200, 16'h0000);

        // R1 reset mid-run
        wr_reg(1'b1, 16'h0001);
        buf_full = 1'b1; @(negedge clk); buf_full = 1'b0;
        @(negedge clk);
        check("R9 irq up", {15'h0, irq_req}, 16'h1);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R1 evt after reset", evt_value, 16'h0000);
        check("R1 irq after reset", {15'h0, irq_req}, 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule